// File: doc/BRIEF.md
# Parallel Rectangle Overlap Node

This block is one node of a two-dimensional spatial index tree. It has a grid of slots, `SLOTS_X` wide and `SLOTS_Y` tall (2 by 2 by default). Each slot stores one axis-aligned rectangle, given by its lower corner and its upper corner in unsigned coordinates, together with a pointer. At a leaf node the pointer refers to the object's data; at an inner node it refers to a child node. A load port writes one slot per cycle and can also mark that slot empty. A separate strobe sets the node's only node-level state, a flag that says whether the node is a leaf.

A query rectangle is presented for one cycle. Every slot compares it against its own rectangle in the same cycle, so no split point has to be chosen. One cycle later the node returns everything as a single group: a hit bit for each slot, every slot's pointer and the leaf flag, qualified by a one-cycle `resultValid` pulse. An outer traversal engine uses the hit bits either to queue child nodes or to collect matching objects.

Top module: `mbr_overlap_node`

## Requirements
- R1: After reset, `resultValid` is 0, `hitVec` and `ptrVec` are all zeros, the leaf flag is 0 and every slot is empty.
- R2: `resultValid` is 1 in exactly the cycle after a cycle with `queryValid` high, and 0 after every cycle with `queryValid` low.
- R3: A slot reports a hit when it holds a rectangle and the two rectangles intersect on both axes: query lowX <= slot highX, query highX >= slot lowX, and the same two tests on y. Coordinates are unsigned and edges that only touch count as a hit.
- R4: An empty slot never reports a hit, whatever the query.
- R5: Slot number k = y*SLOTS_X + x. It is written when `loadIdx` = k, reports on `hitVec[k]` and returns its pointer on `ptrVec[k*PTR_W +: PTR_W]`. The pointers of all slots are returned with every result, whether or not the slot hit.
- R6: A cycle with `leafWr` high stores `leafIn` as the leaf flag. `resultLeaf` returns the flag as it stood when the query was presented.
- R7: When a load and a query fall in the same cycle, the query is judged against the slot contents from before that load. The load takes effect for later queries.
- R8: In cycles without a query, `hitVec`, `ptrVec` and `resultLeaf` hold their last values.
- R9: A load with `loadMark` = 0 empties the addressed slot. A load with `loadMark` = 1 fills the slot with the given rectangle and pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadValid | input | 1 | Write one slot this cycle |
| loadIdx | input | IDX_W | Slot number to write (y*SLOTS_X + x) |
| loadMark | input | 1 | 1 fills the slot, 0 empties it |
| loadLowX | input | COORD_W | Lower x of the rectangle to store |
| loadLowY | input | COORD_W | Lower y of the rectangle to store |
| loadHighX | input | COORD_W | Upper x of the rectangle to store |
| loadHighY | input | COORD_W | Upper y of the rectangle to store |
| loadPtr | input | PTR_W | Child or data pointer to store |
| leafWr | input | 1 | Write the leaf flag this cycle |
| leafIn | input | 1 | New leaf flag value |
| queryValid | input | 1 | Query rectangle present this cycle |
| queryLowX | input | COORD_W | Query lower x |
| queryLowY | input | COORD_W | Query lower y |
| queryHighX | input | COORD_W | Query upper x |
| queryHighY | input | COORD_W | Query upper y |
| resultValid | output | 1 | Result group valid, one cycle after the query |
| hitVec | output | SLOT_N | Hit bit for each slot |
| ptrVec | output | SLOT_N*PTR_W | Pointers of all slots, slot k in bits k*PTR_W upward |
| resultLeaf | output | 1 | Leaf flag that goes with the result |

## Verification
A slot load and a query can arrive in the same cycle, and the result must reflect the slot contents from before the write. The bench provokes this by presenting a query while it rewrites a slot in that cycle with a rectangle and pointer chosen so that the hit bit and the pointer are different from the old ones. It checks that the first result still shows the old hit and pointer, and that an identical query one cycle later shows the new ones. Around this, it sweeps every query interval over a small coordinate range against several slot layouts, including empty slots and rectangles at the ends of the full coordinate range. Each expected hit is computed from the inclusive interval rule.

// File: rtl/mbr_node_pkg.sv
package mbr_node_pkg;

  parameter int COORD_W = 16;

  typedef struct packed {
    logic [COORD_W-1:0] lowX;
    logic [COORD_W-1:0] lowY;
    logic [COORD_W-1:0] highX;
    logic [COORD_W-1:0] highY;
  } rect_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrSlot;   // write the selected slot
    logic wrMark;   // new occupancy of that slot
    logic wrLeaf;   // update the leaf flag
    logic leafVal;  // new leaf flag
    logic cmp;      // capture the comparison results
  } strobe_t;

endpackage

// File: rtl/mbr_node_ctrl.sv
module mbr_node_ctrl
  import mbr_node_pkg::*;
#(
  parameter int SLOT_N = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadValid,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic              loadMark,
  input  logic              leafWr,
  input  logic              leafIn,
  input  logic              queryValid,
  output strobe_t           stb,
  output logic [SLOT_N-1:0] slotSel,
  output logic              resultValid
);

  // one-hot decode of the slot number; numbers past the last slot select nothing
  always_comb begin
    slotSel = '0;
    for (int k = 0; k < SLOT_N; k++) begin
      slotSel[k] = (loadIdx == IDX_W'(k));
    end
  end

  always_comb begin
    stb.wrSlot  = loadValid;
    stb.wrMark  = loadMark;
    stb.wrLeaf  = leafWr;
    stb.leafVal = leafIn;
    stb.cmp     = queryValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= queryValid;
  end

  AST_RESULT_AFTER_QUERY: assert property (@(posedge clk) disable iff (!rstN)
    queryValid |=> resultValid); // R2
  AST_NO_RESULT_UNASKED: assert property (@(posedge clk) disable iff (!rstN)
    !queryValid |=> !resultValid); // R2
  AST_SINGLE_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel)); // R5

endmodule

// File: rtl/mbr_node_dp.sv
module mbr_node_dp
  import mbr_node_pkg::*;
#(
  parameter int SLOT_N = 4,
  parameter int PTR_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [SLOT_N-1:0]       slotSel,
  input  rect_t                   loadRect,
  input  logic [PTR_W-1:0]        loadPtr,
  input  rect_t                   queryRect,
  output logic [SLOT_N-1:0]       hitVec,
  output logic [SLOT_N*PTR_W-1:0] ptrVec,
  output logic                    resultLeaf
);

  logic                    leafFlag;
  logic [SLOT_N-1:0]       hitNow;
  logic [SLOT_N-1:0]       slotValid;
  logic [SLOT_N*PTR_W-1:0] ptrNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           leafFlag <= 1'b0;
    else if (stb.wrLeaf) leafFlag <= stb.leafVal;
  end

  for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
    rect_t            slotRect;
    logic [PTR_W-1:0] slotPtr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[k] <= 1'b0;
        slotRect     <= '0;
        slotPtr      <= '0;
      end else if (stb.wrSlot && slotSel[k]) begin
        slotValid[k] <= stb.wrMark;
        slotRect     <= loadRect;
        slotPtr      <= loadPtr;
      end
    end

    // inclusive interval test on both axes
    always_comb begin
      hitNow[k] = slotValid[k]
                && (queryRect.lowX  <= slotRect.highX)
                && (queryRect.highX >= slotRect.lowX)
                && (queryRect.lowY  <= slotRect.highY)
                && (queryRect.highY >= slotRect.lowY);
    end
    assign ptrNow[k*PTR_W +: PTR_W] = slotPtr;

    AST_EMPTY_SLOT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
      (stb.cmp && !slotValid[k]) |=> !hitVec[k]); // R4
  end

  // result group is captured only on a query, from pre-load slot state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitVec     <= '0;
      ptrVec     <= '0;
      resultLeaf <= 1'b0;
    end else if (stb.cmp) begin
      hitVec     <= hitNow;
      ptrVec     <= ptrNow;
      resultLeaf <= leafFlag;
    end
  end

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cmp |=> ($stable(hitVec) && $stable(ptrVec) && $stable(resultLeaf))); // R8
  AST_LEAF_RETURNED: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmp |=> (resultLeaf == $past(leafFlag))); // R6

endmodule

// File: rtl/mbr_overlap_node.sv
module mbr_overlap_node
  import mbr_node_pkg::*;
#(
  parameter int SLOTS_X = 2,
  parameter int SLOTS_Y = 2,
  parameter int PTR_W   = 16,
  localparam int SLOT_N = SLOTS_X * SLOTS_Y,
  localparam int IDX_W  = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadValid,
  input  logic [IDX_W-1:0]        loadIdx,
  input  logic                    loadMark,
  input  logic [COORD_W-1:0]      loadLowX,
  input  logic [COORD_W-1:0]      loadLowY,
  input  logic [COORD_W-1:0]      loadHighX,
  input  logic [COORD_W-1:0]      loadHighY,
  input  logic [PTR_W-1:0]        loadPtr,
  input  logic                    leafWr,
  input  logic                    leafIn,
  input  logic                    queryValid,
  input  logic [COORD_W-1:0]      queryLowX,
  input  logic [COORD_W-1:0]      queryLowY,
  input  logic [COORD_W-1:0]      queryHighX,
  input  logic [COORD_W-1:0]      queryHighY,
  output logic                    resultValid,
  output logic [SLOT_N-1:0]       hitVec,
  output logic [SLOT_N*PTR_W-1:0] ptrVec,
  output logic                    resultLeaf
);

  strobe_t           stb;
  logic [SLOT_N-1:0] slotSel;
  rect_t             loadRect;
  rect_t             queryRect;

  assign loadRect  = '{lowX: loadLowX, lowY: loadLowY, highX: loadHighX, highY: loadHighY};
  assign queryRect = '{lowX: queryLowX, lowY: queryLowY, highX: queryHighX, highY: queryHighY};

  mbr_node_ctrl #(.SLOT_N(SLOT_N), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIdx(loadIdx),
    .loadMark(loadMark), .leafWr(leafWr), .leafIn(leafIn),
    .queryValid(queryValid), .stb(stb), .slotSel(slotSel),
    .resultValid(resultValid)
  );

  mbr_node_dp #(.SLOT_N(SLOT_N), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .slotSel(slotSel),
    .loadRect(loadRect), .loadPtr(loadPtr), .queryRect(queryRect),
    .hitVec(hitVec), .ptrVec(ptrVec), .resultLeaf(resultLeaf)
  );

endmodule

// File: tb/mbr_overlap_node_tb_top.sv
module mbr_overlap_node_tb_top;
  localparam int N  = 4;
  localparam int PW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 0, loadMark = 0, leafWr = 0, leafIn = 0, queryValid = 0;
  logic [1:0] loadIdx = '0;
  logic [CW-1:0] loadLowX = '0, loadLowY = '0, loadHighX = '0, loadHighY = '0;
  logic [PW-1:0] loadPtr = '0;
  logic [CW-1:0] queryLowX = '0, queryLowY = '0, queryHighX = '0, queryHighY = '0;
  logic resultValid, resultLeaf;
  logic [N-1:0] hitVec;
  logic [N*PW-1:0] ptrVec;

  int checks = 0;
  int fails = 0;

  // bench model of the slots
  logic [CW-1:0] mLx[N], mLy[N], mHx[N], mHy[N];
  logic [PW-1:0] mPtr[N];
  logic          mVal[N];
  logic          mLeaf;

  always #4 clk = ~clk;

  mbr_overlap_node dut_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadIdx(loadIdx),
    .loadMark(loadMark), .loadLowX(loadLowX), .loadLowY(loadLowY),
    .loadHighX(loadHighX), .loadHighY(loadHighY), .loadPtr(loadPtr),
    .leafWr(leafWr), .leafIn(leafIn), .queryValid(queryValid),
    .queryLowX(queryLowX), .queryLowY(queryLowY), .queryHighX(queryHighX),
    .queryHighY(queryHighY), .resultValid(resultValid), .hitVec(hitVec),
    .ptrVec(ptrVec), .resultLeaf(resultLeaf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expHits(input logic [CW-1:0] lx, ly, hx, hy);
    logic [N-1:0] h;
    for (int k = 0; k < N; k++)
      h[k] = mVal[k] && lx <= mHx[k] && hx >= mLx[k] && ly <= mHy[k] && hy >= mLy[k];
    return h;
  endfunction

  function automatic logic [N*PW-1:0] expPtrs();
    logic [N*PW-1:0] p;
    for (int k = 0; k < N; k++) p[k*PW +: PW] = mPtr[k];
    return p;
  endfunction

  // drive the load inputs (caller ends the cycle)
  task automatic setLoad(input int k, input logic mark, input logic [CW-1:0] lx, ly, hx, hy,
                         input logic [PW-1:0] p);
    loadValid = 1; loadIdx = 2'(k); loadMark = mark;
    loadLowX = lx; loadLowY = ly; loadHighX = hx; loadHighY = hy; loadPtr = p;
  endtask

  task automatic modelLoad(input int k, input logic mark, input logic [CW-1:0] lx, ly, hx, hy,
                           input logic [PW-1:0] p);
    mVal[k] = mark; mLx[k] = lx; mLy[k] = ly; mHx[k] = hx; mHy[k] = hy; mPtr[k] = p;
  endtask

  task automatic doLoad(input int k, input logic mark, input logic [CW-1:0] lx, ly, hx, hy,
                        input logic [PW-1:0] p);
    @(negedge clk);
    setLoad(k, mark, lx, ly, hx, hy, p);
    modelLoad(k, mark, lx, ly, hx, hy, p);
    @(negedge clk);
    loadValid = 0;
  endtask

  task automatic doLeaf(input logic v);
    @(negedge clk);
    leafWr = 1; leafIn = v; mLeaf = v;
    @(negedge clk);
    leafWr = 0;
  endtask

  // query with expected values taken from the model before any same-cycle load
  task automatic doQuery(input logic [CW-1:0] lx, ly, hx, hy, input string req);
    logic [N-1:0] eh;
    logic [N*PW-1:0] ep;
    logic el;
    eh = expHits(lx, ly, hx, hy);
    ep = expPtrs();
    el = mLeaf;
    if (!loadValid) @(negedge clk);
    queryValid = 1; queryLowX = lx; queryLowY = ly; queryHighX = hx; queryHighY = hy;
    @(negedge clk);
    queryValid = 0; loadValid = 0;
    chk(resultValid === 1'b1, "R2 valid pulse", 64'(resultValid), 64'd1);
    chk(hitVec === eh, req, 64'(hitVec), 64'(eh));
    chk(ptrVec === ep, "R5 pointers", 64'(ptrVec), 64'(ep));
    chk(resultLeaf === el, "R6 leaf", 64'(resultLeaf), 64'(el));
  endtask

  task automatic sweep(input string req);
    for (int lx = 0; lx < 4; lx++)
      for (int hx = lx; hx < 4; hx++)
        for (int ly = 0; ly < 4; ly++)
          for (int hy = ly; hy < 4; hy++)
            doQuery(CW'(lx), CW'(ly), CW'(hx), CW'(hy), req);
  endtask

  task automatic loadSet(input int s);
    for (int k = 0; k < N; k++) begin
      int lx, ly, hx, hy;
      lx = (k + s) % 4;
      hx = lx + (s % 2) + (k / 2); if (hx > 3) hx = 3;
      ly = (3 * k + s) % 4;
      hy = ly + ((k + s) % 3);     if (hy > 3) hy = 3;
      doLoad(k, 1'b1, CW'(lx), CW'(ly), CW'(hx), CW'(hy), PW'(16'h100 * (s + 1) + k));
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) modelLoad(k, 1'b0, '0, '0, '0, '0, '0);
    mLeaf = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(resultValid === 1'b0, "R1 resultValid", 64'(resultValid), 0);
    chk(hitVec === '0, "R1 hitVec", 64'(hitVec), 0);
    chk(ptrVec === '0, "R1 ptrVec", 64'(ptrVec), 0);
    chk(resultLeaf === 1'b0, "R1 leaf", 64'(resultLeaf), 0);
    doQuery('0, '0, 16'hFFFF, 16'hFFFF, "R1 R4 all slots empty after reset");
    @(negedge clk);
    chk(resultValid === 1'b0, "R2 single-cycle pulse", 64'(resultValid), 0);

    // R3 R5 sweeps over two layouts
    loadSet(0);
    sweep("R3 overlap set0");
    doLeaf(1'b1);
    loadSet(1);
    sweep("R3 overlap set1 leaf");
    // R8 hold without a query
    begin
      logic [N-1:0] hh; logic [N*PW-1:0] pp;
      hh = hitVec; pp = ptrVec;
      doLoad(2, 1'b1, 16'd9, 16'd9, 16'd9, 16'd9, 16'hBEEF);
      doLeaf(1'b0);
      repeat (3) @(negedge clk);
      chk(hitVec === hh, "R8 hits hold", 64'(hitVec), 64'(hh));
      chk(ptrVec === pp, "R8 ptrs hold", 64'(ptrVec), 64'(pp));
      chk(resultLeaf === 1'b1, "R8 leaf holds", 64'(resultLeaf), 1);
    end
    // R9 empty a slot, R4 it stays silent
    doLoad(3, 1'b0, 16'd0, 16'd0, 16'd3, 16'd3, 16'h0333);
    sweep("R4 R9 emptied slot");

    // boundary coordinates at ends of the range
    doLoad(0, 1'b1, 16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hA000);
    doLoad(1, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hA001);
    doQuery(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R3 touching upper corner");
    doQuery(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R3 touching origin");
    doQuery(16'h0001, 16'h0001, 16'hFFFD, 16'hFFFE, "R3 gap on both ends");
    doQuery(16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFE, "R3 x hit y miss");

    // R7 load and query in the same cycle
    doLoad(2, 1'b1, 16'd0, 16'd0, 16'd1, 16'd1, 16'h0202);
    @(negedge clk);
    setLoad(2, 1'b1, 16'd50, 16'd50, 16'd60, 16'd60, 16'h0F0F);
    doQuery(16'd1, 16'd1, 16'd1, 16'd1, "R7 query sees old slot");
    modelLoad(2, 1'b1, 16'd50, 16'd50, 16'd60, 16'd60, 16'h0F0F);
    doQuery(16'd1, 16'd1, 16'd1, 16'd1, "R7 later query sees new slot");
    doQuery(16'd55, 16'd40, 16'd70, 16'd50, "R7 new rectangle hit");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule